// File: doc/BRIEF.md
# Hash Sigma Mixing Unit

This block is a scalar functional unit for a processor datapath. Each request applies one fixed linear mixing function to a single 64-bit source operand. These are the rotate, shift and XOR functions that hash compression rounds and message schedules use. An op code selects the function. Ten functions are available: the four 32-bit SHA-256 functions, the two 32-bit SM3 permutations and the four 64-bit SHA-512 functions.

A single three-term network computes every function. A constant table decodes the op code into three terms. Each term is a right-rotate, a logical right shift, a plain pass-through of the operand, or nothing. Each term also carries a fixed amount and a lane width of 32 or 64 bits. The unit XORs the three terms together and registers the sum.

The result appears one cycle after the request, together with an output valid strobe. The unit has no state machine. It has a single pipeline stage that is either loaded by a request or holds its value.

Top module: `sigma_unit`

## Requirements
- R1: Op 0 returns the XOR of 32-bit right-rotations of operand[31:0] by 2, 13 and 22. Op 1 does the same with rotations by 6, 11 and 25.
- R2: Op 2 returns the XOR of 32-bit right-rotations by 7 and 18 and a logical right shift by 3. Op 3 returns the XOR of right-rotations by 17 and 19 and a logical right shift by 10.
- R3: Op 4 returns x XOR rotr32(x,15) XOR rotr32(x,23). Op 5 returns x XOR rotr32(x,9) XOR rotr32(x,17). In both, x is operand[31:0].
- R4: Op 6 returns the XOR of 64-bit right-rotations of the operand by 28, 34 and 39. Op 7 does the same with rotations by 14, 18 and 41.
- R5: Op 8 returns the XOR of 64-bit right-rotations by 1 and 8 and a logical right shift by 7. Op 9 returns the XOR of 64-bit right-rotations by 19 and 61 and a logical right shift by 6.
- R6: For ops 0 to 5, operand bits [63:32] have no effect, and result bits [63:32] are zero.
- R7: out_valid equals in_valid delayed by one clock. The result of a request appears on the clock edge that follows it.
- R8: An op code from 10 to 15 yields a result of zero.
- R9: In a cycle without in_valid, out_result keeps its previous value.
- R10: After reset, out_valid is 0 and out_result is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| in_op | input | 4 | Function select, encoded as in R1 to R5 and R8 |
| in_operand | input | 64 | Source operand |
| out_valid | output | 1 | Result valid, one cycle after the request |
| out_result | output | 64 | Registered result |

## Verification
On every cycle, the assertions check the one-cycle valid timing and the hold of the result when there is no request. They also check that the upper half is zero after a 32-bit op, and that the result is zero after an undefined op. Only the bench's scenarios can show that the correct rotation constants are applied for each op. The bench compares random operands against reference functions, and it checks directed corner operands. It also shows that garbage in the upper operand half leaves a 32-bit result unchanged.

// File: rtl/sigma_pkg.sv
package sigma_pkg;

    localparam int DATA_W    = 64;
    localparam int HALF_W    = DATA_W / 2;
    localparam int AMT_W     = $clog2(DATA_W);
    localparam int OP_W      = 4;
    localparam int NUM_TERMS = 3;

    typedef enum logic [1:0] {
        TERM_NONE = 2'd0,
        TERM_ROT  = 2'd1,
        TERM_SHR  = 2'd2,
        TERM_PASS = 2'd3
    } term_kind_e;

    typedef struct packed {
        term_kind_e       kind;
        logic [AMT_W-1:0] amt;
    } term_cfg_t;

    typedef enum logic [OP_W-1:0] {
        OP_S256_SUM0 = 4'd0,
        OP_S256_SUM1 = 4'd1,
        OP_S256_SIG0 = 4'd2,
        OP_S256_SIG1 = 4'd3,
        OP_SM3_P0    = 4'd4,
        OP_SM3_P1    = 4'd5,
        OP_S512_SUM0 = 4'd6,
        OP_S512_SUM1 = 4'd7,
        OP_S512_SIG0 = 4'd8,
        OP_S512_SIG1 = 4'd9
    } sigma_op_e;

    function automatic term_cfg_t mk_term(term_kind_e k, int unsigned a);
        term_cfg_t t;
        t.kind = k;
        t.amt  = AMT_W'(a);
        return t;
    endfunction

endpackage

// File: rtl/sigma_const_rom.sv
module sigma_const_rom
    import sigma_pkg::*;
(
    input  logic [OP_W-1:0]              op,
    output term_cfg_t [NUM_TERMS-1:0]    cfg,
    output logic                         narrow
);
    always_comb begin
        cfg    = '0;
        narrow = 1'b1;
        unique case (op)
            OP_S256_SUM0: cfg = {mk_term(TERM_ROT, 22), mk_term(TERM_ROT, 13), mk_term(TERM_ROT, 2)};
            OP_S256_SUM1: cfg = {mk_term(TERM_ROT, 25), mk_term(TERM_ROT, 11), mk_term(TERM_ROT, 6)};
            OP_S256_SIG0: cfg = {mk_term(TERM_SHR, 3),  mk_term(TERM_ROT, 18), mk_term(TERM_ROT, 7)};
            OP_S256_SIG1: cfg = {mk_term(TERM_SHR, 10), mk_term(TERM_ROT, 19), mk_term(TERM_ROT, 17)};
            OP_SM3_P0:    cfg = {mk_term(TERM_ROT, 23), mk_term(TERM_ROT, 15), mk_term(TERM_PASS, 0)};
            OP_SM3_P1:    cfg = {mk_term(TERM_ROT, 17), mk_term(TERM_ROT, 9),  mk_term(TERM_PASS, 0)};
            OP_S512_SUM0: begin
                cfg    = {mk_term(TERM_ROT, 39), mk_term(TERM_ROT, 34), mk_term(TERM_ROT, 28)};
                narrow = 1'b0;
            end
            OP_S512_SUM1: begin
                cfg    = {mk_term(TERM_ROT, 41), mk_term(TERM_ROT, 18), mk_term(TERM_ROT, 14)};
                narrow = 1'b0;
            end
            OP_S512_SIG0: begin
                cfg    = {mk_term(TERM_SHR, 7), mk_term(TERM_ROT, 8), mk_term(TERM_ROT, 1)};
                narrow = 1'b0;
            end
            OP_S512_SIG1: begin
                cfg    = {mk_term(TERM_SHR, 6), mk_term(TERM_ROT, 61), mk_term(TERM_ROT, 19)};
                narrow = 1'b0;
            end
            default: begin
                cfg    = '0;
                narrow = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/sigma_term.sv
module sigma_term
    import sigma_pkg::*;
(
    input  term_cfg_t          cfg,
    input  logic               narrow,
    input  logic [DATA_W-1:0]  x,
    output logic [DATA_W-1:0]  y
);
    logic [HALF_W-1:0]   lo;
    logic [DATA_W-1:0]   dbl_lo;
    logic [2*DATA_W-1:0] dbl_x;
    logic [HALF_W-1:0]   rot_lo;
    logic [DATA_W-1:0]   rot_x;

    always_comb begin
        lo     = x[HALF_W-1:0];
        dbl_lo = {lo, lo} >> cfg.amt[AMT_W-2:0];
        dbl_x  = {x, x} >> cfg.amt;
        rot_lo = dbl_lo[HALF_W-1:0];
        rot_x  = dbl_x[DATA_W-1:0];
        unique case (cfg.kind)
            TERM_ROT:  y = narrow ? {{HALF_W{1'b0}}, rot_lo} : rot_x;
            TERM_SHR:  y = narrow ? {{HALF_W{1'b0}}, lo >> cfg.amt} : (x >> cfg.amt);
            TERM_PASS: y = narrow ? {{HALF_W{1'b0}}, lo} : x;
            default:   y = '0;
        endcase
    end
endmodule

// File: rtl/sigma_unit.sv
module sigma_unit
    import sigma_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [OP_W-1:0]    in_op,
    input  logic [DATA_W-1:0]  in_operand,
    output logic               out_valid,
    output logic [DATA_W-1:0]  out_result
);
    term_cfg_t [NUM_TERMS-1:0] cfg;
    logic                      narrow;
    logic [DATA_W-1:0]         term_y [NUM_TERMS];
    logic [DATA_W-1:0]         mix_sum;

    sigma_const_rom u_rom (
        .op     (in_op),
        .cfg    (cfg),
        .narrow (narrow)
    );

    for (genvar g = 0; g < NUM_TERMS; g++) begin : g_term
        sigma_term u_term (
            .cfg    (cfg[g]),
            .narrow (narrow),
            .x      (in_operand),
            .y      (term_y[g])
        );
    end

    always_comb begin
        mix_sum = '0;
        for (int i = 0; i < NUM_TERMS; i++) begin
            mix_sum = mix_sum ^ term_y[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_result <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_result <= mix_sum;
            end
        end
    end
endmodule

// File: rtl/sigma_unit_chk.sv
module sigma_unit_chk
    import sigma_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               in_valid,
    input logic [OP_W-1:0]    in_op,
    input logic               out_valid,
    input logic [DATA_W-1:0]  out_result
);
    assert_valid_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_valid_drops_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    assert_upper_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op < 4'd6) |=> (out_result[DATA_W-1:HALF_W] == '0));
    assert_undef_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op > 4'd9) |=> (out_result == '0));
    assert_hold_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_result));
endmodule

bind sigma_unit sigma_unit_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_op      (in_op),
    .out_valid  (out_valid),
    .out_result (out_result)
);

// File: tb/tb_sigma_unit.sv
`timescale 1ns/1ps
module tb_sigma_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [3:0]  in_op = '0;
    logic [63:0] in_operand = '0;
    logic        out_valid;
    logic [63:0] out_result;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    sigma_unit dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .in_operand(in_operand), .out_valid(out_valid), .out_result(out_result)
    );

    always #10 clk = ~clk;

    function automatic logic [31:0] r32(logic [31:0] v, int n);
        return (v >> n) | (v << (32 - n));
    endfunction
    function automatic logic [63:0] r64(logic [63:0] v, int n);
        return (v >> n) | (v << (64 - n));
    endfunction

    function automatic logic [63:0] ref_mix(logic [3:0] op, logic [63:0] v);
        logic [31:0] w;
        w = v[31:0];
        case (op)
            4'd0: return {32'h0, r32(w,2) ^ r32(w,13) ^ r32(w,22)};
            4'd1: return {32'h0, r32(w,6) ^ r32(w,11) ^ r32(w,25)};
            4'd2: return {32'h0, r32(w,7) ^ r32(w,18) ^ (w >> 3)};
            4'd3: return {32'h0, r32(w,17) ^ r32(w,19) ^ (w >> 10)};
            4'd4: return {32'h0, w ^ r32(w,15) ^ r32(w,23)};
            4'd5: return {32'h0, w ^ r32(w,9) ^ r32(w,17)};
            4'd6: return r64(v,28) ^ r64(v,34) ^ r64(v,39);
            4'd7: return r64(v,14) ^ r64(v,18) ^ r64(v,41);
            4'd8: return r64(v,1) ^ r64(v,8) ^ (v >> 7);
            4'd9: return r64(v,19) ^ r64(v,61) ^ (v >> 6);
            default: return 64'h0;
        endcase
    endfunction

    function automatic string req_of(logic [3:0] op);
        case (op)
            4'd0, 4'd1: return "R1";
            4'd2, 4'd3: return "R2";
            4'd4, 4'd5: return "R3";
            4'd6, 4'd7: return "R4";
            4'd8, 4'd9: return "R5";
            default:    return "R8";
        endcase
    endfunction

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive at negedge, sample 1ns after the capturing posedge
    task automatic issue(logic [3:0] op, logic [63:0] v);
        @(negedge clk);
        in_valid   = 1'b1;
        in_op      = op;
        in_operand = v;
        @(posedge clk);
        #1;
        check("R7", {63'h0, out_valid}, 64'h1);
        check(req_of(op), out_result, ref_mix(op, v));
    endtask

    task automatic idle_cycle(logic [3:0] op, logic [63:0] v, logic [63:0] held);
        @(negedge clk);
        in_valid   = 1'b0;
        in_op      = op;
        in_operand = v;
        @(posedge clk);
        #1;
        check("R7", {63'h0, out_valid}, 64'h0);
        check("R9", out_result, held);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin : stim
        logic [63:0] v;
        logic [63:0] r_lo;
        void'($urandom(32'd1234));
        #35;
        check("R10", {63'h0, out_valid}, 64'h0);
        check("R10", out_result, 64'h0);
        rst_n = 1'b1;

        // directed: one per op with easy patterns
        for (int op = 0; op < 16; op++) begin
            issue(4'(op), 64'h0000_0000_0000_0001);
            issue(4'(op), 64'hFFFF_FFFF_FFFF_FFFF);
            issue(4'(op), 64'h8000_0000_8000_0000);
        end

        // R6: upper operand half ignored by 32-bit ops
        for (int op = 0; op < 6; op++) begin
            v = {$urandom(), $urandom()};
            issue(4'(op), {32'h0, v[31:0]});
            r_lo = out_result;
            issue(4'(op), {~v[63:32] | 32'h1, v[31:0]});
            check("R6", out_result, r_lo);
            check("R6", {32'h0, out_result[63:32]}, 64'h0);
        end

        // R9: idle cycles hold the last result while inputs change
        issue(4'd6, 64'h0123_4567_89AB_CDEF);
        r_lo = out_result;
        idle_cycle(4'd9, 64'hDEAD_BEEF_0000_1111, r_lo);
        idle_cycle(4'd12, 64'h0, r_lo);

        // random mix, including back-to-back and gaps
        for (int k = 0; k < 600; k++) begin
            v = {$urandom(), $urandom()};
            issue(4'($urandom_range(15, 0)), v);
            if ($urandom_range(3, 0) == 0) begin
                r_lo = out_result;
                idle_cycle(4'($urandom_range(15, 0)), {$urandom(), $urandom()}, r_lo);
            end
        end

        // R10: reset mid-run clears state
        @(negedge clk);
        in_valid = 1'b1;
        in_op = 4'd7;
        in_operand = 64'hA5A5_5A5A_1234_8765;
        @(posedge clk);
        #1;
        rst_n = 1'b0;
        #1;
        check("R10", {63'h0, out_valid}, 64'h0);
        check("R10", out_result, 64'h0);
        in_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule